// File: doc/BRIEF.md
# Error Interrupt Aggregator with Injection

This block collects error event pulses from three families of sources: bus errors, ECC RAM errors and processor/IP errors. It holds each event in a sticky 32-bit status bank. Software reads the banks through a simple 32-bit register port. It acknowledges errors by writing ones to a separate clear register for each bank. The processor/IP banks also have mask registers. Every pending status bit that is not masked contributes to a single registered, level-high error interrupt.

The set of ECC banks that physically exist is a build-time range (`ECC_LO`..`ECC_HI`, at most slots 0..11). Slots outside that range cost no storage. They read as zero and ignore writes. A 16-bit pseudo-error register lets firmware inject test errors into processor/IP bank 0, so the whole path to the interrupt can be exercised without a real fault.

Top module: `err_aggregator`

## Requirements
- R1: After reset, every status bank reads 0, every processor/IP mask register reads 0xFFFFFFFF, and `err_irq_o` is 0.
- R2: A 1 on bit b of bus error input bank k (bits 32k+b of `bus_err_i`) sets bit b of the bus status register at byte address 0x070+4k on the next clock edge. The bit stays set after the input returns to 0.
- R3: A write to the bus clear register at 0x080+4k clears exactly those status bits of bank k that are 1 in the write data. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: ECC slot k, for ECC_LO <= k <= ECC_HI, has its status at 0x090+4k and its clear register at 0x0E0+4k. It is fed from `ecc_err_i` bits 32(k-ECC_LO)+b. It latches and clears with the same rules as R2 and R3.
- R5: ECC status and clear addresses of slots outside ECC_LO..ECC_HI read 0, and writes to them change nothing.
- R6: Processor/IP bank k (k < 4) has its status at 0x338+4k, its clear register at 0x348+4k and its mask register at 0x358+4k. The mask register is read/write. Status latches and clears as in R2 and R3, whatever the mask value.
- R7: A processor/IP status bit contributes to the interrupt only while its mask bit is 0. A masked pending bit keeps the interrupt low.
- R8: `err_irq_o` is registered. It rises one cycle after an unmasked status bit becomes set. It falls one cycle after the last unmasked pending bit clears.
- R9: A write to 0x370 ORs write data bits 15:0 into processor/IP bank 0 status bits 15:0 on the next edge. Bits 31:16 of that write are ignored, and 0x370 reads as 0.
- R10: Unmapped or unaligned addresses read 0, and writes to them change no state. Status addresses are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| bus_err_i | input | 32*BUS_N | Bus error event pulses, bank k in bits 32k+31:32k |
| ecc_err_i | input | 32*(ECC_HI-ECC_LO+1) | ECC error event pulses for the configured slots |
| ip_err_i | input | 32*IP_N | Processor/IP error event pulses |
| err_irq_o | output | 1 | Combined error interrupt, level high |

## Verification
Each status bank either loses a pending bit or gains a bit it should not have. The read port shows this on the very next access to that bank's address. The interrupt output shows it exactly one cycle after the state diverges, because the interrupt comes from a single register fed by the banks. A bad mask or a bad injection path therefore shows up either as a wrong mask or status readback, or as an interrupt edge that comes one cycle early, one cycle late or never. The bench compares read data and the interrupt against its reference model on every clock, so any divergence is caught within one cycle of the access that exposes it.

// File: rtl/erragg_pkg.sv
package erragg_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned ECC_SLOTS = 12;

  localparam logic [11:0] BUS_ST_BASE  = 12'h070;
  localparam logic [11:0] BUS_CLR_BASE = 12'h080;
  localparam logic [11:0] ECC_ST_BASE  = 12'h090;
  localparam logic [11:0] ECC_CLR_BASE = 12'h0E0;
  localparam logic [11:0] IP_ST_BASE   = 12'h338;
  localparam logic [11:0] IP_CLR_BASE  = 12'h348;
  localparam logic [11:0] IP_MSK_BASE  = 12'h358;
  localparam logic [11:0] INJ_ADDR     = 12'h370;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_BUS_ST,
    SEL_BUS_CLR,
    SEL_ECC_ST,
    SEL_ECC_CLR,
    SEL_IP_ST,
    SEL_IP_CLR,
    SEL_IP_MSK,
    SEL_INJ
  } reg_sel_e;

  // Sticky update: a new event wins over a clear of the same bit.
  function automatic logic [WORD_W-1:0] sticky_next(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] evt,
    input logic [WORD_W-1:0] clr
  );
    return (cur & ~clr) | evt;
  endfunction

  // True when an aligned address falls on slot lo..hi of a word array at base.
  function automatic logic in_win(
    input logic [11:0] a,
    input logic [11:0] base,
    input int unsigned lo,
    input int unsigned hi
  );
    int unsigned k;
    k = 32'(a - base) >> 2;
    return (a >= base) && (a[1:0] == 2'b00) && (k >= lo) && (k <= hi);
  endfunction

  // Slot number relative to the first built slot.
  function automatic logic [3:0] slot_of(
    input logic [11:0] a,
    input logic [11:0] base,
    input int unsigned lo
  );
    return 4'((32'(a - base) >> 2) - lo);
  endfunction

endpackage

// File: rtl/erragg_dec.sv
module erragg_dec
  import erragg_pkg::*;
#(
  parameter int unsigned BUS_N  = 4,
  parameter int unsigned ECC_LO = 0,
  parameter int unsigned ECC_HI = 11,
  parameter int unsigned IP_N   = 4
) (
  input  logic [11:0] addr_i,
  output reg_sel_e    sel_o,
  output logic [3:0]  slot_o
);

  always_comb begin
    sel_o  = SEL_NONE;
    slot_o = '0;
    if (in_win(addr_i, BUS_ST_BASE, 0, BUS_N - 1)) begin
      sel_o  = SEL_BUS_ST;
      slot_o = slot_of(addr_i, BUS_ST_BASE, 0);
    end else if (in_win(addr_i, BUS_CLR_BASE, 0, BUS_N - 1)) begin
      sel_o  = SEL_BUS_CLR;
      slot_o = slot_of(addr_i, BUS_CLR_BASE, 0);
    end else if (in_win(addr_i, ECC_ST_BASE, ECC_LO, ECC_HI)) begin
      sel_o  = SEL_ECC_ST;
      slot_o = slot_of(addr_i, ECC_ST_BASE, ECC_LO);
    end else if (in_win(addr_i, ECC_CLR_BASE, ECC_LO, ECC_HI)) begin
      sel_o  = SEL_ECC_CLR;
      slot_o = slot_of(addr_i, ECC_CLR_BASE, ECC_LO);
    end else if (in_win(addr_i, IP_ST_BASE, 0, IP_N - 1)) begin
      sel_o  = SEL_IP_ST;
      slot_o = slot_of(addr_i, IP_ST_BASE, 0);
    end else if (in_win(addr_i, IP_CLR_BASE, 0, IP_N - 1)) begin
      sel_o  = SEL_IP_CLR;
      slot_o = slot_of(addr_i, IP_CLR_BASE, 0);
    end else if (in_win(addr_i, IP_MSK_BASE, 0, IP_N - 1)) begin
      sel_o  = SEL_IP_MSK;
      slot_o = slot_of(addr_i, IP_MSK_BASE, 0);
    end else if (addr_i == INJ_ADDR) begin
      sel_o  = SEL_INJ;
    end
  end

endmodule

// File: rtl/erragg_bank.sv
module erragg_bank
  import erragg_pkg::*;
#(
  parameter bit HAS_MASK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt_i,
  input  logic [WORD_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic              msk_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] pend_o
);

  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= sticky_next(status_q, evt_i | set_i, clr_bits);
  end

  generate
    if (HAS_MASK) begin : g_mask
      logic [WORD_W-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '1;
        else if (msk_we_i) mask_q <= wdata_i;
      end
      assign mask_o = mask_q;
    end else begin : g_nomask
      logic unused_msk_we;
      assign unused_msk_we = msk_we_i;
      assign mask_o = '0;
    end
  endgenerate

  assign status_o = status_q;
  assign pend_o   = status_q & ~mask_o;

endmodule

// File: rtl/err_aggregator.sv
module err_aggregator
  import erragg_pkg::*;
#(
  parameter int unsigned BUS_N  = 4,
  parameter int unsigned ECC_LO = 0,
  parameter int unsigned ECC_HI = 11,
  parameter int unsigned IP_N   = 4,
  parameter int unsigned INJ_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_we,
  input  logic [11:0]                         reg_addr,
  input  logic [31:0]                         reg_wdata,
  output logic [31:0]                         reg_rdata,
  input  logic [32*BUS_N-1:0]                 bus_err_i,
  input  logic [32*(ECC_HI-ECC_LO+1)-1:0]     ecc_err_i,
  input  logic [32*IP_N-1:0]                  ip_err_i,
  output logic                                err_irq_o
);

  localparam int unsigned ECC_N = ECC_HI - ECC_LO + 1;

  reg_sel_e   sel;
  logic [3:0] slot;

  logic [32*BUS_N-1:0] bus_st_flat;
  logic [32*ECC_N-1:0] ecc_st_flat;
  logic [32*IP_N-1:0]  ip_st_flat;
  logic [32*IP_N-1:0]  ip_msk_flat;
  logic [32*IP_N-1:0]  ip_pend_flat;
  logic                inj_we;
  logic                any_pend;
  logic                irq_q;

  erragg_dec #(
    .BUS_N (BUS_N),
    .ECC_LO(ECC_LO),
    .ECC_HI(ECC_HI),
    .IP_N  (IP_N)
  ) u_dec (
    .addr_i(reg_addr),
    .sel_o (sel),
    .slot_o(slot)
  );

  assign inj_we = reg_we && (sel == SEL_INJ);

  generate
    for (genvar g = 0; g < BUS_N; g++) begin : g_bus
      logic [31:0] unused_msk;
      logic [31:0] unused_pend;
      erragg_bank #(.HAS_MASK(1'b0)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (bus_err_i[32*g +: 32]),
        .set_i   (32'h0),
        .clr_we_i(reg_we && sel == SEL_BUS_CLR && slot == 4'(g)),
        .msk_we_i(1'b0),
        .wdata_i (reg_wdata),
        .status_o(bus_st_flat[32*g +: 32]),
        .mask_o  (unused_msk),
        .pend_o  (unused_pend)
      );
    end

    for (genvar g = 0; g < ECC_N; g++) begin : g_ecc
      logic [31:0] unused_msk;
      logic [31:0] unused_pend;
      erragg_bank #(.HAS_MASK(1'b0)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (ecc_err_i[32*g +: 32]),
        .set_i   (32'h0),
        .clr_we_i(reg_we && sel == SEL_ECC_CLR && slot == 4'(g)),
        .msk_we_i(1'b0),
        .wdata_i (reg_wdata),
        .status_o(ecc_st_flat[32*g +: 32]),
        .mask_o  (unused_msk),
        .pend_o  (unused_pend)
      );
    end

    for (genvar g = 0; g < IP_N; g++) begin : g_ip
      logic [31:0] inj_bits;
      if (g == 0) begin : g_inj
        assign inj_bits = inj_we ? 32'(reg_wdata[INJ_W-1:0]) : 32'h0;
      end else begin : g_noinj
        assign inj_bits = 32'h0;
      end
      erragg_bank #(.HAS_MASK(1'b1)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (ip_err_i[32*g +: 32]),
        .set_i   (inj_bits),
        .clr_we_i(reg_we && sel == SEL_IP_CLR && slot == 4'(g)),
        .msk_we_i(reg_we && sel == SEL_IP_MSK && slot == 4'(g)),
        .wdata_i (reg_wdata),
        .status_o(ip_st_flat[32*g +: 32]),
        .mask_o  (ip_msk_flat[32*g +: 32]),
        .pend_o  (ip_pend_flat[32*g +: 32])
      );
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_BUS_ST: reg_rdata = bus_st_flat[32*slot +: 32];
      SEL_ECC_ST: reg_rdata = ecc_st_flat[32*slot +: 32];
      SEL_IP_ST:  reg_rdata = ip_st_flat[32*slot +: 32];
      SEL_IP_MSK: reg_rdata = ip_msk_flat[32*slot +: 32];
      default:    reg_rdata = 32'h0;
    endcase
  end

  assign any_pend = (|bus_st_flat) | (|ecc_st_flat) | (|ip_pend_flat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend;
  end

  assign err_irq_o = irq_q;

endmodule

// File: rtl/erragg_chk.sv
module erragg_chk
  import erragg_pkg::*;
#(
  parameter int unsigned BUS_N = 4,
  parameter int unsigned ECC_N = 12,
  parameter int unsigned IP_N  = 4,
  parameter int unsigned INJ_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [11:0]          reg_addr,
  input logic [INJ_W-1:0]     inj_data,
  input logic [32*BUS_N-1:0]  bus_err_i,
  input logic [32*BUS_N-1:0]  bus_st,
  input logic [32*ECC_N-1:0]  ecc_st,
  input logic [32*IP_N-1:0]   ip_st,
  input logic [32*IP_N-1:0]   ip_msk,
  input logic                 any_pend,
  input logic                 err_irq_o
);

  logic bus_clr_hit;
  logic inj_hit;
  assign bus_clr_hit = reg_we && (reg_addr >= BUS_CLR_BASE) && (reg_addr < ECC_ST_BASE);
  assign inj_hit     = reg_we && (reg_addr == INJ_ADDR);

  // R2
  bus_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_i != '0) |=> ((bus_st & $past(bus_err_i)) == $past(bus_err_i)));

  // R3
  bus_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clr_hit |=> (($past(bus_st) & ~bus_st) == '0));

  // R9
  inj_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_hit |=> ((ip_st[INJ_W-1:0] & $past(inj_data)) == $past(inj_data)));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> err_irq_o);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !err_irq_o);

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_st == '0) && (ecc_st == '0) && ((ip_st & ~ip_msk) == '0)) |=> !err_irq_o);

endmodule

bind err_aggregator erragg_chk #(
  .BUS_N(BUS_N),
  .ECC_N(ECC_HI - ECC_LO + 1),
  .IP_N (IP_N),
  .INJ_W(INJ_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .inj_data (reg_wdata[INJ_W-1:0]),
  .bus_err_i(bus_err_i),
  .bus_st   (bus_st_flat),
  .ecc_st   (ecc_st_flat),
  .ip_st    (ip_st_flat),
  .ip_msk   (ip_msk_flat),
  .any_pend (any_pend),
  .err_irq_o(err_irq_o)
);

// File: tb/err_aggregator_bench.sv
`timescale 1ns/1ps
module err_aggregator_bench;

  localparam int LO = 1;
  localparam int HI = 4;
  localparam int NE = HI - LO + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] bus_err = '0;
  logic [32*NE-1:0] ecc_err = '0;
  logic [127:0] ip_err = '0;
  logic         irq;

  int total = 0;
  int bad = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  err_aggregator #(.ECC_LO(LO), .ECC_HI(HI)) u_err_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_err_i(bus_err),
    .ecc_err_i(ecc_err), .ip_err_i(ip_err), .err_irq_o(irq)
  );

  // Reference model state
  logic [31:0] bus_m [4];
  logic [31:0] ecc_m [12];
  logic [31:0] ip_m [4];
  logic [31:0] msk_m [4];
  bit irq_m;

  function automatic bit m_pend();
    bit p = 0;
    for (int k = 0; k < 4; k++) p |= (bus_m[k] != 0) || ((ip_m[k] & ~msk_m[k]) != 0);
    for (int k = 0; k < 12; k++) p |= (ecc_m[k] != 0);
    return p;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    for (int k = 0; k < 4; k++) begin
      if (a == 12'h070 + 12'(4*k)) return bus_m[k];
      if (a == 12'h338 + 12'(4*k)) return ip_m[k];
      if (a == 12'h358 + 12'(4*k)) return msk_m[k];
    end
    for (int k = LO; k <= HI; k++)
      if (a == 12'h090 + 12'(4*k)) return ecc_m[k];
    return 32'h0;
  endfunction

  function automatic string req_of(input logic [11:0] a);
    if (a >= 12'h070 && a < 12'h090) return "R2";
    if (a >= 12'h090 && a < 12'h130) return "R4";
    if (a >= 12'h338 && a < 12'h368) return "R6";
    if (a == 12'h370) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin bus_m[k] = 0; ip_m[k] = 0; msk_m[k] = 32'hFFFF_FFFF; end
      for (int k = 0; k < 12; k++) ecc_m[k] = 0;
      irq_m = 0;
    end else begin
      irq_m = m_pend();
      for (int k = 0; k < 4; k++) begin
        logic [31:0] c, e;
        c = (reg_we && reg_addr == 12'h080 + 12'(4*k)) ? reg_wdata : 32'h0;
        bus_m[k] = (bus_m[k] & ~c) | bus_err[32*k +: 32];
        c = (reg_we && reg_addr == 12'h348 + 12'(4*k)) ? reg_wdata : 32'h0;
        e = ip_err[32*k +: 32];
        if (k == 0 && reg_we && reg_addr == 12'h370) e |= reg_wdata & 32'h0000_FFFF;
        ip_m[k] = (ip_m[k] & ~c) | e;
        if (reg_we && reg_addr == 12'h358 + 12'(4*k)) msk_m[k] = reg_wdata;
      end
      for (int k = LO; k <= HI; k++) begin
        logic [31:0] c;
        c = (reg_we && reg_addr == 12'h0E0 + 12'(4*k)) ? reg_wdata : 32'h0;
        ecc_m[k] = (ecc_m[k] & ~c) | ecc_err[32*(k-LO) +: 32];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (live) begin
      chk("R8 irq vs model", {31'h0, irq}, {31'h0, irq_m});
      chk(req_of(reg_addr), reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(posedge clk); #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic irq_is(input bit exp, input string tag);
    chk(tag, {31'h0, irq}, {31'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    // R1 reset state
    rd(12'h358, 32'hFFFF_FFFF, "R1 mask reset");
    rd(12'h070, 32'h0, "R1 status reset");
    irq_is(1'b0, "R1 irq reset");

    // R2 latch and stick
    @(negedge clk); bus_err[64 +: 32] = 32'h0001_0001;
    @(negedge clk); bus_err = '0;
    repeat (2) @(negedge clk);
    rd(12'h078, 32'h0001_0001, "R2 sticky bus status");
    irq_is(1'b1, "R8 irq set by bus");

    // R3 partial clear, and event beats clear
    wr(12'h088, 32'h0000_0001);
    rd(12'h078, 32'h0001_0000, "R3 partial clear");
    @(negedge clk); reg_we = 1'b1; reg_addr = 12'h088; reg_wdata = 32'h0001_0000;
    bus_err[64 +: 32] = 32'h0001_0000;
    @(negedge clk); reg_we = 1'b0; bus_err = '0;
    rd(12'h078, 32'h0001_0000, "R3 event wins over clear");
    wr(12'h088, 32'h0001_0000);
    irq_is(1'b1, "R8 irq holds one cycle after clear");
    @(posedge clk); #1;
    irq_is(1'b0, "R8 irq drops");
    rd(12'h078, 32'h0, "R3 full clear");

    // R4 ECC slots at both ends of the range
    @(negedge clk); ecc_err[0 +: 32] = 32'h0000_00A5; ecc_err[96 +: 32] = 32'h8000_0000;
    @(negedge clk); ecc_err = '0;
    rd(12'h094, 32'h0000_00A5, "R4 ecc low slot");
    rd(12'h0A0, 32'h8000_0000, "R4 ecc high slot");
    wr(12'h0E4, 32'h0000_0005);
    rd(12'h094, 32'h0000_00A0, "R4 ecc clear");

    // R5 slots outside the range
    rd(12'h090, 32'h0, "R5 below range");
    rd(12'h0A4, 32'h0, "R5 above range");
    wr(12'h0E0, 32'hFFFF_FFFF);
    wr(12'h0F4, 32'hFFFF_FFFF);
    rd(12'h094, 32'h0000_00A0, "R5 out-of-range clear ignored");
    wr(12'h094, 32'h0);
    rd(12'h094, 32'h0000_00A0, "R10 status read-only");
    wr(12'h0E4, 32'hFFFF_FFFF);
    wr(12'h0F0, 32'hFFFF_FFFF);
    rd(12'h0A0, 32'h0, "R4 ecc high clear");
    @(posedge clk); #1;
    irq_is(1'b0, "R8 idle");

    // R6 / R7 processor-IP masking
    @(negedge clk); ip_err[32 +: 32] = 32'h0000_0008;
    @(negedge clk); ip_err = '0;
    repeat (2) @(negedge clk);
    rd(12'h33C, 32'h0000_0008, "R6 ip status while masked");
    irq_is(1'b0, "R7 masked keeps irq low");
    wr(12'h35C, 32'h0);
    rd(12'h35C, 32'h0, "R6 mask readback");
    irq_is(1'b1, "R7 unmasked raises irq");
    wr(12'h34C, 32'hFFFF_FFFF);
    rd(12'h33C, 32'h0, "R6 ip clear");

    // R9 injection into bank 0
    wr(12'h370, 32'hFFFF_0004);
    rd(12'h338, 32'h0000_0004, "R9 inject sets bank0 bit");
    rd(12'h370, 32'h0, "R9 inject reads zero");
    irq_is(1'b0, "R9 injected bit masked");
    wr(12'h358, 32'h0);
    @(posedge clk); #1;
    irq_is(1'b1, "R9 injected bit raises irq");
    wr(12'h348, 32'h0000_0004);

    // R10 unmapped and unaligned
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 32'h0, "R10 unmapped");
    rd(12'h071, 32'h0, "R10 unaligned");
    rd(12'h338, 32'h0, "R10 unmapped write no effect");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule